// File: doc/BRIEF.md
# Two-Stage Keyed Watchdog Timer

This block is a watchdog with two chained countdown stages. Software programs it through a small register port. Stage one counts down from its own preload value. When stage one expires, the block can raise an interrupt and stage two starts counting from a second preload value. When stage two expires, the block records a timeout and, if rebooting is enabled, requests a system reset. Software keeps the system alive by restarting the count before stage one runs out.

The two preload registers and the reload register are write-protected. A protected write is accepted only after a two-byte key has been written to the reload register. Each key grants exactly one protected write. A lock bit makes the enable setting sticky, so software cannot switch the watchdog off once it is locked. The timeout flag lives in the power-on domain. It survives the reset that the watchdog itself requests, so boot code can read it to learn why the system restarted.

Registers, by word address: 0 config, 1 control, 2 stage-one preload, 3 stage-two preload, 4 reload/status, 5 live count (read-only).

Top module: `kwd_watchdog`

## Requirements
- R1: A write to address 2, 3 or 4 takes effect only when the key has been written first. The key is 0x80 and then 0x86, in that order, in bits [7:0] of address 4. Such a write without the key leaves the register and the countdown unchanged.
- R2: A completed key permits exactly one protected write, and protection returns right after it. If the write that follows 0x80 is anything other than a 0x86 key write, the sequence is aborted and must start again with 0x80.
- R3: A keyed write to address 4 with bit 8 set restarts stage one from its preload and restarts the tick divider. Stage one expires on the clock edge that lies DIV*(P1+1) cycles after the restart edge.
- R4: On stage-one expiry, stage two loads its preload P2 and expires DIV*(P2+1) cycles later. In watchdog mode, stage-two expiry asserts the reset request only when config bit 5 is set. The request stays high until a keepalive, a disable or a reset.
- R5: Address 4 bit 9 reads a timeout flag that is set by stage-two expiry in watchdog mode. The flag survives the warm reset input and is cleared by a keyed write of 1 to bit 9 or by power-on reset.
- R6: Address 5 reads the live 20-bit count of the running stage. After a restart it holds P1 and drops by one on each tick.
- R7: DIV is 2^PRESC_W when config bit 2 is clear and 2^FAST_W when it is set.
- R8: Config bits [1:0] set the interrupt type on stage-one expiry. Values 0 and 2 give a level that holds until keepalive or disable. Value 1 gives a single-cycle pulse. Value 3 gives no interrupt.
- R9: Control bit 0 is the lock, bit 1 the enable and bit 2 the mode select. Once the lock is set, the lock, enable and mode bits cannot be cleared until a reset.
- R10: While the enable is clear, the count holds the stage-one preload. From the second edge after the enable clears, neither irq_o nor rst_req_o is high.
- R11: With control bit 2 set (periodic mode), stage-two expiry restarts stage one instead of requesting a reset, and it leaves the timeout flag alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Synchronous active-low power-on reset, clears everything including the timeout flag |
| rst_n | input | 1 | Synchronous active-low warm reset, clears everything except the timeout flag |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr, combinational |
| irq_o | output | 1 | Stage-one interrupt |
| rst_req_o | output | 1 | System reset request on stage-two expiry |

## Verification
Every write lands on the clock edge that samples it. Reads are combinational, so the bench samples read data one nanosecond after it sets the address at a falling edge. Expiry outputs are registered and change on the edge DIV*(P+1) cycles after the restart edge, where the restart edge is the keepalive write or the enabling write. The bench counts falling edges from that edge and records the first cycle each output is high. A disable reaches the outputs one edge later than the write, and the bench samples after that extra edge. The timing sweep covers every pair of preloads from 0 to 5 with the fast divider, and a single run covers the slow divider.

// File: rtl/kwd_pkg.sv
// Shared constants and types for the keyed two-stage watchdog.
// Assumes word addressing of a small register file, up to 8 registers.
package kwd_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CFG    = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd1;
    localparam logic [ADDR_W-1:0] A_PRE1   = 3'd2;
    localparam logic [ADDR_W-1:0] A_PRE2   = 3'd3;
    localparam logic [ADDR_W-1:0] A_RELOAD = 3'd4;
    localparam logic [ADDR_W-1:0] A_COUNT  = 3'd5;

    localparam logic [7:0] KEY_FIRST  = 8'h80;
    localparam logic [7:0] KEY_SECOND = 8'h86;

    localparam int BIT_KEEP   = 8;
    localparam int BIT_FLAG   = 9;
    localparam int CFG_FAST   = 2;
    localparam int CFG_REBOOT = 5;
    localparam logic [5:0] CFG_MASK = 6'b100111;

    localparam int CTL_LOCK = 0;
    localparam int CTL_EN   = 1;
    localparam int CTL_MODE = 2;

    localparam logic [1:0] IRQ_PULSE = 2'd1;
    localparam logic [1:0] IRQ_NONE  = 2'd3;

    typedef enum logic [1:0] {ST_ONE, ST_TWO, ST_DONE} stage_e;
    typedef enum logic [1:0] {KEY_IDLE, KEY_ARMED, KEY_OPEN} key_e;
endpackage

// File: rtl/kwd_prescaler.sv
// Tick divider: emits a one-cycle tick every 2^PRESC_W cycles, or every
// 2^FAST_W cycles when fast is set. Assumes FAST_W < PRESC_W. A clear
// restarts the phase so that the first tick comes a full period later.
module kwd_prescaler #(
    parameter int PRESC_W = 15,
    parameter int FAST_W  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic fast,
    output logic tick
);
    logic [PRESC_W-1:0] cnt;
    logic               fast_hit;

    // Free-running phase counter, held at zero while cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else               cnt <= cnt + 1'b1;
    end

    generate
        if (FAST_W == 0) begin : g_fast_every
            assign fast_hit = 1'b1;
        end else begin : g_fast_div
            assign fast_hit = &cnt[FAST_W-1:0];
        end
    endgenerate

    // Tick selection between slow and fast period.
    always_comb tick = fast ? fast_hit : &cnt;
endmodule

// File: rtl/kwd_keyseq.sv
// Unlock key sequencer: KEY_FIRST then KEY_SECOND written to the reload
// register opens one protected write. Any other protected write while
// armed aborts the sequence. Any protected write while open closes it.
module kwd_keyseq
    import kwd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_prot,
    input  logic       wr_reload,
    input  logic [7:0] key_byte,
    output logic       open
);
    key_e st;

    // Key state progression.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= KEY_IDLE;
        end else begin
            unique case (st)
                KEY_IDLE:  if (wr_reload && key_byte == KEY_FIRST) st <= KEY_ARMED;
                KEY_ARMED: if (wr_prot)
                               st <= (wr_reload && key_byte == KEY_SECOND) ? KEY_OPEN : KEY_IDLE;
                KEY_OPEN:  if (wr_prot) st <= KEY_IDLE;
                default:   st <= KEY_IDLE;
            endcase
        end
    end

    // Grant is visible during the cycle of the protected write.
    always_comb open = (st == KEY_OPEN);
endmodule

// File: rtl/kwd_countdown.sv
// Two chained countdown stages. Each stage lasts (preload+1) ticks. While
// disabled or restarted, it reloads stage one and drops both outputs.
// Assumes tick is a single-cycle strobe.
module kwd_countdown
    import kwd_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic             tick,
    input  logic [CNT_W-1:0] pre1,
    input  logic [CNT_W-1:0] pre2,
    input  logic             periodic,
    input  logic             reboot_en,
    input  logic [1:0]       irq_type,
    output logic [CNT_W-1:0] count,
    output stage_e           stage,
    output logic             exp_wd,
    output logic             irq,
    output logic             rst_req
);
    logic hold;
    logic zero;
    logic exp1;
    logic exp2;

    // Expiry strobes for each stage.
    always_comb begin
        hold   = !en || restart;
        zero   = (count == '0);
        exp1   = !hold && tick && zero && stage == ST_ONE;
        exp2   = !hold && tick && zero && stage == ST_TWO;
        exp_wd = exp2 && !periodic;
    end

    // Stage and count progression.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage <= ST_ONE;
            count <= '1;
        end else if (hold) begin
            stage <= ST_ONE;
            count <= pre1;
        end else if (tick) begin
            unique case (stage)
                ST_ONE: begin
                    if (zero) begin
                        stage <= ST_TWO;
                        count <= pre2;
                    end else begin
                        count <= count - 1'b1;
                    end
                end
                ST_TWO: begin
                    if (zero) begin
                        stage <= periodic ? ST_ONE : ST_DONE;
                        count <= periodic ? pre1 : count;
                    end else begin
                        count <= count - 1'b1;
                    end
                end
                default: begin
                    stage <= ST_DONE;
                end
            endcase
        end
    end

    // Stage-one interrupt, level or pulse by type.
    always_ff @(posedge clk) begin
        if (!rst_n || hold)                 irq <= 1'b0;
        else if (exp1 && irq_type != IRQ_NONE) irq <= 1'b1;
        else if (irq_type == IRQ_PULSE)     irq <= 1'b0;
    end

    // Reset request on stage-two expiry in watchdog mode.
    always_ff @(posedge clk) begin
        if (!rst_n || hold)             rst_req <= 1'b0;
        else if (exp_wd && reboot_en)   rst_req <= 1'b1;
    end
endmodule

// File: rtl/kwd_watchdog.sv
// Top of the keyed two-stage watchdog: register file, key gating,
// lock handling and the power-on timeout flag. Register reads are
// combinational. Assumes DATA_W > CNT_W and DATA_W > BIT_FLAG.
module kwd_watchdog
    import kwd_pkg::*;
#(
    parameter int CNT_W   = 20,
    parameter int PRESC_W = 15,
    parameter int FAST_W  = 5,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o,
    output logic              rst_req_o
);
    logic             sys_rst_n;
    logic [5:0]       cfg_q;
    logic             lock_q;
    logic             en_q;
    logic             func_q;
    logic [CNT_W-1:0] pre1_q;
    logic [CNT_W-1:0] pre2_q;
    logic             flag_q;
    logic             key_open;
    logic             prot_wr;
    logic             reload_wr;
    logic             grant;
    logic             restart;
    logic             tick;
    logic             exp_wd;
    logic [CNT_W-1:0] count;
    stage_e           stage;
    logic             wdata_unused;

    assign wdata_unused = &{1'b0, reg_wdata[DATA_W-1:CNT_W]};

    // Write decode and key grant.
    always_comb begin
        sys_rst_n = por_n && rst_n;
        reload_wr = reg_we && reg_addr == A_RELOAD;
        prot_wr   = reg_we && (reg_addr == A_PRE1 || reg_addr == A_PRE2 || reload_wr);
        grant     = prot_wr && key_open;
        restart   = grant && reg_addr == A_RELOAD && reg_wdata[BIT_KEEP];
    end

    kwd_keyseq u_key (
        .clk       (clk),
        .rst_n     (sys_rst_n),
        .wr_prot   (prot_wr),
        .wr_reload (reload_wr),
        .key_byte  (reg_wdata[7:0]),
        .open      (key_open)
    );

    kwd_prescaler #(.PRESC_W(PRESC_W), .FAST_W(FAST_W)) u_presc (
        .clk   (clk),
        .rst_n (sys_rst_n),
        .clr   (!en_q || restart),
        .fast  (cfg_q[CFG_FAST]),
        .tick  (tick)
    );

    kwd_countdown #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (sys_rst_n),
        .en        (en_q),
        .restart   (restart),
        .tick      (tick),
        .pre1      (pre1_q),
        .pre2      (pre2_q),
        .periodic  (func_q),
        .reboot_en (cfg_q[CFG_REBOOT]),
        .irq_type  (cfg_q[1:0]),
        .count     (count),
        .stage     (stage),
        .exp_wd    (exp_wd),
        .irq       (irq_o),
        .rst_req   (rst_req_o)
    );

    // Config and control registers, lock makes control sticky.
    always_ff @(posedge clk) begin
        if (!sys_rst_n) begin
            cfg_q  <= '0;
            lock_q <= 1'b0;
            en_q   <= 1'b0;
            func_q <= 1'b0;
        end else if (reg_we && reg_addr == A_CFG) begin
            cfg_q <= reg_wdata[5:0] & CFG_MASK;
        end else if (reg_we && reg_addr == A_CTRL) begin
            lock_q <= lock_q || reg_wdata[CTL_LOCK];
            en_q   <= reg_wdata[CTL_EN]   || (lock_q && en_q);
            func_q <= lock_q ? func_q : reg_wdata[CTL_MODE];
        end
    end

    // Protected preload registers.
    always_ff @(posedge clk) begin
        if (!sys_rst_n) begin
            pre1_q <= '1;
            pre2_q <= '1;
        end else if (grant && reg_addr == A_PRE1) begin
            pre1_q <= reg_wdata[CNT_W-1:0];
        end else if (grant && reg_addr == A_PRE2) begin
            pre2_q <= reg_wdata[CNT_W-1:0];
        end
    end

    // Timeout flag in the power-on domain, set wins over clear.
    always_ff @(posedge clk) begin
        if (!por_n)                                                 flag_q <= 1'b0;
        else if (exp_wd)                                            flag_q <= 1'b1;
        else if (grant && reg_addr == A_RELOAD && reg_wdata[BIT_FLAG]) flag_q <= 1'b0;
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CFG:    reg_rdata[5:0] = cfg_q;
            A_CTRL:   reg_rdata[2:0] = {func_q, en_q, lock_q};
            A_PRE1:   reg_rdata[CNT_W-1:0] = pre1_q;
            A_PRE2:   reg_rdata[CNT_W-1:0] = pre2_q;
            A_RELOAD: reg_rdata[BIT_FLAG] = flag_q;
            A_COUNT:  reg_rdata[CNT_W-1:0] = count;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/kwd_watchdog_chk.sv
// Assertion checker for kwd_watchdog, bound to every instance.
// Assumes both resets are synchronous and active low.
module kwd_watchdog_chk
    import kwd_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input logic             clk,
    input logic             sys_rst_n,
    input logic             key_open,
    input logic             prot_wr,
    input logic [CNT_W-1:0] pre1_q,
    input logic             en_q,
    input logic             lock_q,
    input logic             func_q,
    input logic [5:0]       cfg_q,
    input logic             flag_q,
    input stage_e           stage,
    input logic             irq_o,
    input logic             rst_req_o
);
    logic past_ok;

    // Marks cycles whose $past lies after reset.
    always_ff @(posedge clk) begin
        if (!sys_rst_n) past_ok <= 1'b0;
        else            past_ok <= 1'b1;
    end

    a_r1_preload_needs_key: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (past_ok && pre1_q != $past(pre1_q)) |-> $past(key_open));

    a_r2_grant_single_use: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (past_ok && $past(key_open && prot_wr)) |-> !key_open);

    a_r4_reset_needs_reboot: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (past_ok && $rose(rst_req_o)) |-> ($past(cfg_q[CFG_REBOOT]) && !$past(func_q)));

    a_r5_flag_with_reset: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (past_ok && $rose(rst_req_o)) |-> flag_q);

    a_r8_irq_at_stage_one_end: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (past_ok && $rose(irq_o)) |-> (stage == ST_TWO && $past(cfg_q[1:0]) != IRQ_NONE));

    a_r9_lock_keeps_enable: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (past_ok && $past(lock_q && en_q)) |-> (lock_q && en_q));

    a_r10_quiet_when_off: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (past_ok && !$past(en_q)) |-> (!irq_o && !rst_req_o));
endmodule

bind kwd_watchdog kwd_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .sys_rst_n (sys_rst_n),
    .key_open  (key_open),
    .prot_wr   (prot_wr),
    .pre1_q    (pre1_q),
    .en_q      (en_q),
    .lock_q    (lock_q),
    .func_q    (func_q),
    .cfg_q     (cfg_q),
    .flag_q    (flag_q),
    .stage     (stage),
    .irq_o     (irq_o),
    .rst_req_o (rst_req_o)
);

// File: tb/kwd_watchdog_bench.sv
`timescale 1ns/1ps
// Self-checking bench for kwd_watchdog with a small divider (8 slow, 2 fast).
module kwd_watchdog_bench;
    localparam int CNT_W = 20;
    localparam int DW    = 32;
    localparam int DIV_S = 8;
    localparam int DIV_F = 2;
    localparam int ALL1  = (1 << CNT_W) - 1;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic          rst_n = 1'b1;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          irq_o;
    logic          rst_req_o;

    int n_chk  = 0;
    int n_fail = 0;

    kwd_watchdog #(.CNT_W(CNT_W), .PRESC_W(3), .FAST_W(1), .DATA_W(DW)) u_kwd_watchdog (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o), .rst_req_o(rst_req_o)
    );

    always #2.5 clk = ~clk;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic prot(logic [2:0] a, int d);
        wr(3'd4, 32'h80);
        wr(3'd4, 32'h86);
        wr(a, d);
    endtask

    task automatic power_on();
        @(negedge clk);
        por_n = 1'b0;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
    endtask

    task automatic warm();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Records first cycle of irq and of rst_req, and the count at cycle ck.
    task automatic measure(int lim, int ck, output int t_irq, output int t_rst, output int cval);
        t_irq = -1; t_rst = -1; cval = -1;
        reg_addr = 3'd5;
        for (int k = 1; k <= lim; k++) begin
            @(negedge clk);
            #1;
            if (irq_o && t_irq < 0) t_irq = k;
            if (rst_req_o && t_rst < 0) t_rst = k;
            if (k == ck) cval = int'(reg_rdata);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int v, ti, tr, cv, hi, first, last;
        power_on();

        // Reset state
        chk("R10 irq after reset", int'(irq_o), 0);
        chk("R4 rst_req after reset", int'(rst_req_o), 0);
        rd(3'd5, v); chk("R6 count after reset", v, ALL1);
        rd(3'd4, v); chk("R5 flag after reset", v, 0);
        rd(3'd1, v); chk("R9 ctrl after reset", v, 0);

        // R1/R2 key gating
        wr(3'd2, 5);  rd(3'd2, v); chk("R1 pre1 write without key", v, ALL1);
        prot(3'd2, 5); rd(3'd2, v); chk("R1 pre1 keyed write", v, 5);
        wr(3'd2, 7);  rd(3'd2, v); chk("R2 second write after one key", v, 5);
        wr(3'd4, 32'h80); wr(3'd4, 32'h55); wr(3'd4, 32'h86); wr(3'd3, 3);
        rd(3'd3, v); chk("R2 aborted key sequence", v, ALL1);
        wr(3'd4, 32'h80); wr(3'd3, 4); wr(3'd4, 32'h86); wr(3'd3, 4);
        rd(3'd3, v); chk("R2 preload write aborts armed key", v, ALL1);

        // R3/R4/R6/R7 sweep with fast divider, level irq, reboot
        wr(3'd0, 32'h24);
        wr(3'd1, 32'h2);
        for (int p1 = 0; p1 <= 5; p1++) begin
            for (int p2 = 0; p2 <= 5; p2++) begin
                prot(3'd2, p1);
                prot(3'd3, p2);
                prot(3'd4, 32'h100);
                rd(3'd5, v); chk("R6 count at restart", v, p1);
                chk("R3 irq cleared by keepalive", int'(irq_o), 0);
                measure(DIV_F*(p1+p2+2)+4, DIV_F, ti, tr, cv);
                chk("R3 stage one expiry cycle", ti, DIV_F*(p1+1));
                chk("R4 stage two reset cycle", tr, DIV_F*(p1+p2+2));
                chk("R6 count after first tick", cv, (p1 == 0) ? p2 : p1 - 1);
            end
        end

        // R7 slow divider
        power_on();
        wr(3'd0, 32'h20);
        prot(3'd2, 0); prot(3'd3, 1);
        wr(3'd1, 32'h2);
        measure(30, DIV_S, ti, tr, cv);
        chk("R7 slow irq cycle", ti, DIV_S);
        chk("R7 slow reset cycle", tr, DIV_S*3);
        chk("R7 slow count after stage change", cv, 1);

        // R1 keepalive without key has no effect
        power_on();
        wr(3'd0, 32'h24);
        prot(3'd2, 2); prot(3'd3, 5);
        wr(3'd1, 32'h2);
        repeat (3) @(negedge clk);
        wr(3'd4, 32'h100);
        chk("R1 irq before expiry", int'(irq_o), 0);
        @(negedge clk);
        chk("R1 unkeyed keepalive ignored", int'(irq_o), 1);

        // R8 pulse type
        power_on();
        wr(3'd0, 32'h25);
        prot(3'd2, 1); prot(3'd3, 9);
        wr(3'd1, 32'h2);
        hi = 0; first = -1;
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            if (irq_o) begin hi++; if (first < 0) first = k; end
        end
        chk("R8 pulse width", hi, 1);
        chk("R8 pulse cycle", first, DIV_F*2);

        // R8 none type, R4 no reboot, R5 flag set
        power_on();
        wr(3'd0, 32'h07);
        prot(3'd2, 1); prot(3'd3, 1);
        wr(3'd1, 32'h2);
        measure(20, 1, ti, tr, cv);
        chk("R8 type 3 gives no irq", ti, -1);
        chk("R4 no reset without reboot bit", tr, -1);
        rd(3'd4, v); chk("R5 flag set by stage two", v, 32'h200);

        // R5 flag survives warm reset, cleared by keyed write and power-on
        warm();
        rd(3'd4, v); chk("R5 flag after warm reset", v, 32'h200);
        rd(3'd1, v); chk("R9 ctrl cleared by warm reset", v, 0);
        prot(3'd4, 32'h200);
        rd(3'd4, v); chk("R5 flag cleared by keyed write", v, 0);
        wr(3'd0, 32'h24);
        prot(3'd2, 0); prot(3'd3, 0);
        wr(3'd1, 32'h2);
        repeat (6) @(negedge clk);
        chk("R4 reset request", int'(rst_req_o), 1);
        rd(3'd4, v); chk("R5 flag set again", v, 32'h200);
        power_on();
        rd(3'd4, v); chk("R5 flag cleared by power-on", v, 0);

        // R9 lock
        wr(3'd0, 32'h24);
        prot(3'd2, 0); prot(3'd3, 7);
        wr(3'd1, 32'h3);
        wr(3'd1, 32'h0);
        rd(3'd1, v); chk("R9 lock keeps enable", v, 3);
        repeat (2) @(negedge clk);
        chk("R9 locked timer still runs", int'(irq_o), 1);
        warm();
        rd(3'd1, v); chk("R9 lock cleared by reset", v, 0);

        // R10 disabled holds preload, disable drops outputs
        power_on();
        wr(3'd0, 32'h24);
        prot(3'd2, 9);
        hi = 0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (irq_o || rst_req_o) hi++;
        end
        chk("R10 outputs low while disabled", hi, 0);
        rd(3'd5, v); chk("R10 count holds preload", v, 9);
        prot(3'd2, 0); prot(3'd3, 9);
        wr(3'd1, 32'h2);
        repeat (3) @(negedge clk);
        chk("R8 level irq held", int'(irq_o), 1);
        wr(3'd1, 32'h0);
        @(negedge clk);
        chk("R10 disable clears irq", int'(irq_o), 0);
        rd(3'd5, v); chk("R10 count back to preload", v, 0);

        // R11 periodic mode
        power_on();
        wr(3'd0, 32'h25);
        prot(3'd2, 1); prot(3'd3, 0);
        wr(3'd1, 32'h6);
        hi = 0; first = -1; last = -1; tr = 0;
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            if (irq_o) begin hi++; if (first < 0) first = k; last = k; end
            if (rst_req_o) tr++;
        end
        chk("R11 periodic irq count", hi, 2);
        chk("R11 first irq", first, 4);
        chk("R11 second irq after restart", last, 10);
        chk("R11 no reset request", tr, 0);
        rd(3'd4, v); chk("R11 flag untouched", v, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule